// File: doc/BRIEF.md
# Power-On Reset Sequencer with Status Register

This block produces the internal reset for a small 8-bit microcontroller. A power-on event starts a stabilization delay. The delay advances only while the oscillator reports that it is running. While the delay runs, the block pulls the shared open-drain reset pin low, and it holds the core in reset until the pin is seen high again. An external reset, where something outside the chip pulls the pin low with no power-on event, also holds the core in reset. Releasing it costs only a short synchronize-and-stretch and does not run the long delay.

The block also owns one 8-bit miscellaneous register on a simple address, write-enable and data bus. Bit 7 is a sticky power-on flag: hardware sets it and software can only clear it. Bit 0 is the watchdog enable, and its reset value is fixed at build time. Bits 6 to 1 are plain storage. The delay length is chosen at build time: 16 clock cycles, or 4064 when `DELAY_SEL` is 1.

Top module: `por_reset_seq`

## Requirements
- R1: After a power-on event (`por_i` pulse or `rst_ni` assertion), `pin_drive_o` is 1 for exactly 16 cycles with `DELAY_SEL`=0 (4064 with `DELAY_SEL`=1), provided `osc_ready_i` stays high. `core_rst_o` is 1 whenever `pin_drive_o` is 1.
- R2: The delay advances only on cycles with `osc_ready_i` high. Each cycle with it low lengthens the drive period by one cycle.
- R3: A `por_i` pulse during a running delay restarts the count from zero, so a full delay length follows the new pulse.
- R4: After the delay, `core_rst_o` stays 1 for as long as `ext_rst_ni` is low. It falls at the 5th rising clock edge after the pin input rises (2 synchronizer stages, 1 detect, 2 stretch cycles).
- R5: With the core running, a low `ext_rst_ni` raises `core_rst_o` at the 3rd rising edge, and `pin_drive_o` stays 0. On release, reset ends after the same 5-edge path as R4, with no stabilization delay.
- R6: Register bit 7 (power-on flag) is set by every power-on event and is left unchanged by an external reset.
- R7: Writing 0 to bit 7 clears the flag. Writing 1 to bit 7 leaves it unchanged.
- R8: While `core_rst_o` is 1, bits 6..1 are held at 0 and bit 0 at `WDOG_DEFAULT` (default 1). Outside reset, bits 6..0 store the written data.
- R9: The register sits at `REG_ADDR` (default 8'h0C). Writes to other addresses, and all writes while `core_rst_o` is 1, are ignored. Reads of other addresses return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as a power-on event |
| por_i | input | 1 | Synchronous power-on pulse from the supply detector |
| osc_ready_i | input | 1 | Oscillator running; gates the delay count |
| ext_rst_ni | input | 1 | Reset pin level as read back, active low |
| pin_drive_o | output | 1 | 1 pulls the open-drain reset pin low |
| core_rst_o | output | 1 | Active-high reset to the core |
| reg_addr_i | input | 8 | Register bus address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
The hardest situation to reach is the restart of a delay that is already partly counted, together with oscillator-ready dropping in the middle of the count. The bench issues a second power-on pulse ten cycles into a delay, and separately holds `osc_ready_i` low for seven cycles just after a pulse. In both cases it measures the full length of the pin drive at the ports. The bench models the pin as a wired-AND of its own pull-down and `pin_drive_o`, so the block sees its own drive on the pin and the full path back through the synchronizer is exercised.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [1:0] {
    ST_DELAY   = 2'd0,
    ST_HOLD    = 2'd1,
    ST_STRETCH = 2'd2,
    ST_RUN     = 2'd3
  } rst_state_e;

  localparam int unsigned SHORT_DELAY = 16;
  localparam int unsigned LONG_DELAY  = 4064;

  function automatic int unsigned delay_cycles(input bit sel);
    return sel ? LONG_DELAY : SHORT_DELAY;
  endfunction

endpackage

// File: rtl/por_pin_sync.sv
module por_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= 1'b0;
          else         stage_q[i] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= 1'b0;
          else         stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/por_delay_cnt.sv
module por_delay_cnt #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R1
  AST_OSC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cnt_q)); // R2
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/por_misc_reg.sv
module por_misc_reg #(
  parameter int unsigned ADDR_W       = 8,
  parameter logic [7:0]  REG_ADDR     = 8'h0C,
  parameter bit          WDOG_DEFAULT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_evt_i,
  input  logic              core_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam logic [6:0] LOW_DEFAULT = {6'b0, WDOG_DEFAULT};

  logic       por_flag_q;
  logic [6:0] low_q;
  logic       hit;
  logic       wr_ok;

  assign hit   = (addr_i == ADDR_W'(REG_ADDR));
  assign wr_ok = hit && we_i && !core_rst_i;

  // sticky flag: hardware sets, software clears only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       por_flag_q <= 1'b1;
    else if (por_evt_i)                por_flag_q <= 1'b1;
    else if (wr_ok && !wdata_i[7])     por_flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_q <= LOW_DEFAULT;
    else if (core_rst_i) low_q <= LOW_DEFAULT;
    else if (wr_ok)      low_q <= wdata_i[6:0];
  end

  assign rdata_o = hit ? {por_flag_q, low_q} : 8'h00;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_evt_i |=> por_flag_q); // R6
  AST_FLAG_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_evt_i && !por_flag_q) |=> !por_flag_q); // R7
  AST_RST_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_i && !we_i) |=> (low_q == LOW_DEFAULT)); // R8
  AST_NO_WR_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_i && !por_evt_i) |=> $stable(por_flag_q)); // R9

endmodule

// File: rtl/por_reset_seq.sv
module por_reset_seq #(
  parameter bit          DELAY_SEL    = 1'b0,
  parameter bit          WDOG_DEFAULT = 1'b1,
  parameter int unsigned ADDR_W       = 8,
  parameter logic [7:0]  REG_ADDR     = 8'h0C,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STRETCH_LEN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              osc_ready_i,
  input  logic              ext_rst_ni,
  output logic              pin_drive_o,
  output logic              core_rst_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o
);

  import por_seq_pkg::*;

  localparam int unsigned DELAY_LEN = delay_cycles(DELAY_SEL);
  localparam int unsigned SW        = (STRETCH_LEN > 1) ? $clog2(STRETCH_LEN) : 1;
  localparam logic [SW-1:0] ST_LAST = SW'(STRETCH_LEN - 1);

  rst_state_e    state_q, state_d;
  logic [SW-1:0] st_cnt_q, st_cnt_d;
  logic          ext_sync;
  logic          dly_done;

  por_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_rst_ni),
    .sync_o (ext_sync)
  );

  por_delay_cnt #(.LEN(DELAY_LEN)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (por_i),
    .run_i   ((state_q == ST_DELAY) && osc_ready_i),
    .done_o  (dly_done)
  );

  always_comb begin
    state_d  = state_q;
    st_cnt_d = st_cnt_q;
    if (por_i) begin
      state_d = ST_DELAY;
    end else begin
      unique case (state_q)
        ST_DELAY: if (dly_done) state_d = ST_HOLD;
        ST_HOLD: begin
          if (ext_sync) begin
            state_d  = ST_STRETCH;
            st_cnt_d = '0;
          end
        end
        ST_STRETCH: begin
          if (!ext_sync)              state_d = ST_HOLD;
          else if (st_cnt_q == ST_LAST) state_d = ST_RUN;
          else                        st_cnt_d = st_cnt_q + 1'b1;
        end
        ST_RUN: if (!ext_sync) state_d = ST_HOLD;
        default: state_d = ST_DELAY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_DELAY;
      st_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      st_cnt_q <= st_cnt_d;
    end
  end

  assign pin_drive_o = (state_q == ST_DELAY);
  assign core_rst_o  = (state_q != ST_RUN);

  por_misc_reg #(
    .ADDR_W       (ADDR_W),
    .REG_ADDR     (REG_ADDR),
    .WDOG_DEFAULT (WDOG_DEFAULT)
  ) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_evt_i  (por_i),
    .core_rst_i (core_rst_o),
    .addr_i     (reg_addr_i),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o)
  );

  AST_DRIVE_HOLDS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> core_rst_o); // R1
  AST_RELEASE_PIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(ext_sync)); // R4
  AST_EXT_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && !ext_sync && !por_i) |=> (core_rst_o && !pin_drive_o)); // R5

endmodule

// File: tb/por_reset_seq_test.sv
module por_reset_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por = 1'b0;
  logic       osc = 1'b1;
  logic       ext_low = 1'b0;
  logic       pin_drive;
  logic       core_rst;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pin_level;

  int errors = 0;
  int checks = 0;

  localparam logic [7:0] RA = 8'h0C;
  localparam int DLY = 16;
  localparam int REL = 5;

  // open-drain pin: low if bench or block pulls it
  assign pin_level = !(ext_low || pin_drive);

  always #2 clk = ~clk;

  por_reset_seq uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .por_i       (por),
    .osc_ready_i (osc),
    .ext_rst_ni  (pin_level),
    .pin_drive_o (pin_drive),
    .core_rst_o  (core_rst),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, RA,    8'h00, 8'h81},
    '{1'b1, RA,    8'hFF, 8'hFF},
    '{1'b1, RA,    8'h2A, 8'h2A},
    '{1'b1, RA,    8'h80, 8'h00},
    '{1'b1, 8'h0D, 8'h55, 8'h00},
    '{1'b0, RA,    8'h00, 8'h00},
    '{1'b1, RA,    8'h7F, 8'h7F},
    '{1'b1, 8'h0B, 8'h00, 8'h00},
    '{1'b0, RA,    8'h00, 8'h7F}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic por_pulse();
    @(negedge clk) por = 1'b1;
    @(negedge clk) por = 1'b0;
  endtask

  task automatic count_drive(output int n);
    n = 0;
    while (pin_drive && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (core_rst && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic reg_access(input logic wr, input logic [7:0] a,
                            input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    addr = a; wdata = d; we = wr;
    if (wr) begin
      @(negedge clk);
      we = 1'b0;
    end
    #1 r = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] r;

    repeat (3) @(negedge clk);
    check("R1 reset core_rst", int'(core_rst), 1);
    check("R1 reset pin_drive", int'(pin_drive), 1);
    rst_n = 1'b1;
    count_release(n);
    check("R1 core out of reset after power-up", int'(core_rst), 0);
    reg_access(1'b0, RA, 8'h00, r);
    check("R6 flag after power-up", int'(r), 8'h81);

    // register vector walk
    foreach (VEC[i]) begin
      reg_access(VEC[i].wr, VEC[i].a, VEC[i].d, r);
      check($sformatf("R7 R8 R9 vector %0d", i), int'(r), int'(VEC[i].exp));
    end

    // R1 / R4: delay length and release path
    por_pulse();
    count_drive(n);
    check("R1 drive length", n, DLY);
    count_release(n);
    check("R4 release after pin rises", n, REL);
    reg_access(1'b0, RA, 8'h00, r);
    check("R6 flag set by por, R8 defaults", int'(r), 8'h81);

    // R2: oscillator gating
    osc = 1'b0;
    por_pulse();
    repeat (7) @(negedge clk);
    check("R2 drive held while osc low", int'(pin_drive), 1);
    osc = 1'b1;
    count_drive(n);
    check("R2 remaining drive after osc", n, DLY);
    count_release(n);

    // R3: restart mid-delay
    por_pulse();
    repeat (10) @(negedge clk);
    por_pulse();
    count_drive(n);
    check("R3 restart full length", n, DLY);
    count_release(n);

    // R4: pin held low past delay; R9 writes during reset ignored
    ext_low = 1'b1;
    por_pulse();
    addr = RA; wdata = 8'h00; we = 1'b1;
    @(negedge clk) we = 1'b0;
    count_drive(n);
    check("R4 drive length with pin low", n, DLY - 1);
    repeat (20) @(negedge clk);
    check("R4 core held while pin low", int'(core_rst), 1);
    ext_low = 1'b0;
    count_release(n);
    check("R4 release count", n, REL);
    reg_access(1'b0, RA, 8'h00, r);
    check("R9 write during reset ignored", int'(r), 8'h81);

    // clear flag, set storage
    reg_access(1'b1, RA, 8'h3C, r);
    check("R7 clear flag", int'(r), 8'h3C);

    // R5: external reset while running
    @(negedge clk) ext_low = 1'b1;
    @(negedge clk);
    check("R5 core still running edge1", int'(core_rst), 0);
    @(negedge clk);
    check("R5 core still running edge2", int'(core_rst), 0);
    @(negedge clk);
    check("R5 core reset edge3", int'(core_rst), 1);
    check("R5 no pin drive", int'(pin_drive), 0);
    repeat (6) @(negedge clk);
    ext_low = 1'b0;
    count_release(n);
    check("R5 short release", n, REL);
    reg_access(1'b0, RA, 8'h00, r);
    check("R6 flag untouched by ext reset, R8 defaults", int'(r), 8'h01);

    // R6: power-on sets flag again
    por_pulse();
    count_drive(n);
    count_release(n);
    reg_access(1'b0, RA, 8'h00, r);
    check("R6 flag set again", int'(r), 8'h81);
    reg_access(1'b0, 8'hFF, 8'h00, r);
    check("R9 other address reads zero", int'(r), 0);

    finish_run();
  end

endmodule